// File: doc/BRIEF.md
# Periodic Deadline Re-arm Engine

This block re-arms a periodic compare deadline after a channel has expired. Given the previous deadline, the period, the live value of the free-running counter and the channel's pending flag, it advances the deadline by one period and checks whether the new deadline still lies ahead of the counter. If the counter has already passed it, the engine retries. Each retry skips twice as far as the one before, so a channel that has fallen far behind catches up in a bounded number of steps.

The engine also reports how many periods it skipped, as an overrun count. When it has no success after a fixed number of attempts, or when the next skip no longer fits in the deadline width, it stops and raises a failure flag. To arm a channel for the first time, the caller passes the requested first expiry minus one period as the deadline. The first attempt then lands exactly on the requested expiry.

Each attempt drives its candidate deadline out to the comparator first. The engine then waits one cycle before it samples the counter and the pending flag. This gives the comparator time to see the new value and to raise pending if it has already matched.

Top module: `deadline_rearm`

## Requirements
- R1: After reset, deadline_o, overrun_o, done_o and fail_o are all zero.
- R2: Attempt n (n = 0, 1, 2, ...) sets deadline_o to the previous deadline plus period_i shifted left by n bits. Attempt 0 starts from deadline_i, so the first candidate is deadline_i + period_i.
- R3: On an accepted start, overrun_o is set to all ones (minus one in two's complement). Each attempt that advances the deadline adds 2^n to it. A run that succeeds on attempt k therefore ends with overrun_o = 2^(k+1) - 2.
- R4: An attempt succeeds when counter_i, taken as unsigned, is strictly below the candidate deadline, or when pending_i is high at the moment of sampling. If the counter equals the candidate and pending is low, the attempt fails.
- R5: If attempts 0 through MAX_ATTEMPTS-1 (default 20) all fail, the run ends with fail_o high. deadline_o and overrun_o keep the values from the last attempt.
- R6: If period_i shifted by n, or the sum of that skip and the deadline, does not fit in CNT_W bits (default 55), the run ends at once with fail_o high. That attempt changes neither deadline_o nor overrun_o.
- R7: If a run's last attempt has index k, done_o rises 3(k+1) clock edges after the edge that accepts start_i when the run ends by sampling. It rises 3k+1 edges after that edge when the run ends on an overflow.
- R8: done_o stays high for exactly one cycle, on success and on failure alike. fail_o stays valid from that cycle until the next accepted start.
- R9: A start_i pulse that arrives while a run is in progress is ignored. Neither the run's inputs nor its result change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a run when idle |
| deadline_i | input | CNT_W | Previous deadline (first expiry minus one period when first arming) |
| period_i | input | CNT_W | Period in counter ticks |
| counter_i | input | CNT_W | Live counter value |
| pending_i | input | 1 | Channel's comparator-match pending flag |
| deadline_o | output | CNT_W | Candidate or final deadline driven to the comparator |
| overrun_o | output | OVR_W | Periods skipped, two's complement |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Run ended without a usable deadline |

## Verification
Two situations are hard to reach from the ports. The first is the give-up path after twenty misses. The bench reaches it with a period of one and a counter parked near 2^30, so every doubling skip still falls short until the attempt budget runs out. The second is the width overflow. The bench reaches it in two ways: by starting close to the top of the 55-bit range, and by using a period of 2^54 against a saturated counter, so the second attempt's shift itself spills over. The bench also checks the strict-less-than boundary by placing the counter exactly on the candidate deadline, with pending low and with pending high.

// File: rtl/rearm_pkg.sv
package rearm_pkg;

    localparam int CNT_W_DEF        = 55;
    localparam int OVR_W_DEF        = 32;
    localparam int MAX_ATTEMPTS_DEF = 20;

    // Engine sequencing: advance, settle one cycle, then judge.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADV  = 2'd1,
        ST_WAIT = 2'd2,
        ST_CHK  = 2'd3
    } rearm_state_e;

    // End-of-run outcome registered for the done pulse.
    typedef struct packed {
        logic done;
        logic fail;
    } rearm_result_t;

endpackage

// File: rtl/rearm_step.sv
module rearm_step #(
    parameter int CNT_W        = 55,
    parameter int MAX_ATTEMPTS = 20,
    parameter int NW           = 5
) (
    input  logic [CNT_W-1:0] base_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [NW-1:0]    attempt_i,
    output logic [CNT_W-1:0] cand_o,
    output logic             ovf_o
);
    localparam int EW = CNT_W + MAX_ATTEMPTS;

    logic [EW-1:0]    skip_wide;
    logic [CNT_W:0]   sum;
    logic             shift_ovf;

    always_comb begin
        skip_wide = {{MAX_ATTEMPTS{1'b0}}, period_i} << attempt_i;
        shift_ovf = |skip_wide[EW-1:CNT_W];
        sum       = {1'b0, base_i} + {1'b0, skip_wide[CNT_W-1:0]};
        cand_o    = sum[CNT_W-1:0];
        ovf_o     = shift_ovf | sum[CNT_W];
    end
endmodule

// File: rtl/rearm_judge.sv
module rearm_judge #(
    parameter int CNT_W = 55
) (
    input  logic [CNT_W-1:0] counter_i,
    input  logic [CNT_W-1:0] deadline_i,
    input  logic             pending_i,
    output logic             hit_o
);
    logic ahead;

    always_comb begin
        ahead = counter_i < deadline_i;
        hit_o = ahead | pending_i;
    end
endmodule

// File: rtl/rearm_ctrl.sv
module rearm_ctrl
    import rearm_pkg::*;
#(
    parameter int CNT_W        = 55,
    parameter int OVR_W        = 32,
    parameter int MAX_ATTEMPTS = 20,
    parameter int NW           = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] deadline_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] cand_i,
    input  logic             ovf_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] deadline_o,
    output logic [CNT_W-1:0] period_o,
    output logic [NW-1:0]    attempt_o,
    output logic [OVR_W-1:0] overrun_o,
    output logic             done_o,
    output logic             fail_o,
    output logic             busy_o
);
    localparam logic [NW-1:0] LAST_ATTEMPT = NW'(MAX_ATTEMPTS - 1);

    rearm_state_e   state_q;
    logic [CNT_W-1:0] dl_q;
    logic [CNT_W-1:0] per_q;
    logic [NW-1:0]  n_q;
    logic [OVR_W-1:0] ovr_q;
    rearm_result_t  res_q;
    logic           fail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dl_q    <= '0;
            per_q   <= '0;
            n_q     <= '0;
            ovr_q   <= '0;
            res_q   <= '0;
            fail_q  <= 1'b0;
        end else begin
            res_q <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        dl_q    <= deadline_i;
                        per_q   <= period_i;
                        n_q     <= '0;
                        ovr_q   <= '1;
                        fail_q  <= 1'b0;
                        state_q <= ST_ADV;
                    end
                end
                ST_ADV: begin
                    if (ovf_i) begin
                        res_q   <= '{done: 1'b1, fail: 1'b1};
                        fail_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        dl_q    <= cand_i;
                        ovr_q   <= ovr_q + (OVR_W'(1) << n_q);
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: state_q <= ST_CHK;
                ST_CHK: begin
                    if (hit_i) begin
                        res_q   <= '{done: 1'b1, fail: 1'b0};
                        state_q <= ST_IDLE;
                    end else if (n_q == LAST_ATTEMPT) begin
                        res_q   <= '{done: 1'b1, fail: 1'b1};
                        fail_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        n_q     <= n_q + NW'(1);
                        state_q <= ST_ADV;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign deadline_o = dl_q;
    assign period_o   = per_q;
    assign attempt_o  = n_q;
    assign overrun_o  = ovr_q;
    assign done_o     = res_q.done;
    assign fail_o     = fail_q;
    assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/deadline_rearm.sv
module deadline_rearm
    import rearm_pkg::*;
#(
    parameter int CNT_W        = CNT_W_DEF,
    parameter int OVR_W        = OVR_W_DEF,
    parameter int MAX_ATTEMPTS = MAX_ATTEMPTS_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] deadline_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] counter_i,
    input  logic             pending_i,
    output logic [CNT_W-1:0] deadline_o,
    output logic [OVR_W-1:0] overrun_o,
    output logic             done_o,
    output logic             fail_o
);
    localparam int NW = $clog2(MAX_ATTEMPTS + 1);

    logic [CNT_W-1:0] dl_w;
    logic [CNT_W-1:0] per_w;
    logic [CNT_W-1:0] cand_w;
    logic [NW-1:0]    n_w;
    logic             ovf_w;
    logic             hit_w;
    logic             busy_w;

    rearm_step #(.CNT_W(CNT_W), .MAX_ATTEMPTS(MAX_ATTEMPTS), .NW(NW)) step_i (
        .base_i    (dl_w),
        .period_i  (per_w),
        .attempt_i (n_w),
        .cand_o    (cand_w),
        .ovf_o     (ovf_w)
    );

    rearm_judge #(.CNT_W(CNT_W)) judge_i (
        .counter_i  (counter_i),
        .deadline_i (dl_w),
        .pending_i  (pending_i),
        .hit_o      (hit_w)
    );

    rearm_ctrl #(.CNT_W(CNT_W), .OVR_W(OVR_W), .MAX_ATTEMPTS(MAX_ATTEMPTS), .NW(NW)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .deadline_i (deadline_i),
        .period_i   (period_i),
        .cand_i     (cand_w),
        .ovf_i      (ovf_w),
        .hit_i      (hit_w),
        .deadline_o (dl_w),
        .period_o   (per_w),
        .attempt_o  (n_w),
        .overrun_o  (overrun_o),
        .done_o     (done_o),
        .fail_o     (fail_o),
        .busy_o     (busy_w)
    );

    assign deadline_o = dl_w;
endmodule

// File: rtl/rearm_chk.sv
module rearm_chk #(
    parameter int CNT_W = 55,
    parameter int OVR_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [CNT_W-1:0] counter_i,
    input logic             pending_i,
    input logic [CNT_W-1:0] deadline_o,
    input logic [OVR_W-1:0] overrun_o,
    input logic             done_o,
    input logic             fail_o,
    input logic             busy_w
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                           // R8

    AST_FAIL_RISES_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_o) |-> done_o);                                     // R8

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_w);                                           // R7

    AST_SUCCESS_JUSTIFIED: assert property (@(posedge clk) disable iff (rst)
        (done_o && !fail_o) |-> ($past(counter_i) < deadline_o || $past(pending_i))); // R4

    AST_DEADLINE_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        ($past(busy_w) && busy_w && !$stable(deadline_o)) |-> deadline_o > $past(deadline_o)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!busy_w && !start_i) |=> ($stable(deadline_o) && $stable(overrun_o))); // R9

    AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (busy_w && start_i) |=> overrun_o != '1 || $past(overrun_o) == '1); // R9
endmodule

bind deadline_rearm rearm_chk #(.CNT_W(CNT_W), .OVR_W(OVR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .counter_i  (counter_i),
    .pending_i  (pending_i),
    .deadline_o (deadline_o),
    .overrun_o  (overrun_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .busy_w     (busy_w)
);

// File: tb/deadline_rearm_tb_top.sv
module deadline_rearm_tb_top;
    localparam int CW = 55;
    localparam int OW = 32;
    localparam int NV = 10;
    localparam logic [CW-1:0] TOPV = {CW{1'b1}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [CW-1:0] deadline_i = '0;
    logic [CW-1:0] period_i = '0;
    logic [CW-1:0] counter_i = '0;
    logic          pending_i = 1'b0;
    logic [CW-1:0] deadline_o;
    logic [OW-1:0] overrun_o;
    logic          done_o;
    logic          fail_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    deadline_rearm dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .deadline_i(deadline_i),
        .period_i(period_i), .counter_i(counter_i), .pending_i(pending_i),
        .deadline_o(deadline_o), .overrun_o(overrun_o), .done_o(done_o), .fail_o(fail_o)
    );

    // Vector table: input deadline, period, counter, pending; expected deadline, overrun, fail, latency.
    localparam logic [CW-1:0] V_DL  [NV] = '{55'd100, 55'd100, 55'd100, 55'd0, 55'd100,
                                             55'd100, 55'd0, TOPV - 55'd9, 55'd0, 55'd100};
    localparam logic [CW-1:0] V_PER [NV] = '{55'd10, 55'd10, 55'd10, 55'd1, 55'd5,
                                             55'd5, 55'd1, 55'd20, 55'd1 << 54, 55'd10};
    localparam logic [CW-1:0] V_CNT [NV] = '{55'd50, 55'd110, 55'd110, 55'd1000, 55'd104,
                                             55'd105, 55'd1 << 30, 55'd0, TOPV, 55'd5000};
    localparam logic          V_PND [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
                                             1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic [CW-1:0] E_DL  [NV] = '{55'd110, 55'd130, 55'd110, 55'd1023, 55'd105,
                                             55'd115, 55'd1048575, TOPV - 55'd9, 55'd1 << 54, 55'd110};
    localparam logic [OW-1:0] E_OVR [NV] = '{32'd0, 32'd2, 32'd0, 32'd1022, 32'd0,
                                             32'd2, 32'd1048574, 32'hFFFF_FFFF, 32'd0, 32'd0};
    localparam logic          E_FL  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                             1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam int            E_LAT [NV] = '{4, 7, 4, 31, 4, 7, 61, 2, 5, 4};

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Launch a run at a negedge and return the negedges counted until done_o.
    task automatic run(input logic [CW-1:0] dl, input logic [CW-1:0] per,
                       input logic [CW-1:0] cnt, input logic pnd, output int lat);
        @(negedge clk);
        deadline_i = dl; period_i = per; counter_i = cnt; pending_i = pnd; start_i = 1'b1;
        lat = 0;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        if (!done_o) check(1'b0, "R7 watchdog", lat, 0);
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(deadline_o == '0, "R1 deadline", deadline_o, 0);
        check(overrun_o == '0, "R1 overrun", overrun_o, 0);
        check(!done_o && !fail_o, "R1 flags", {done_o, fail_o}, 0);

        for (int i = 0; i < NV; i++) begin
            run(V_DL[i], V_PER[i], V_CNT[i], V_PND[i], lat);
            check(deadline_o == E_DL[i], "R2/R4/R6 deadline", deadline_o, E_DL[i]);
            check(overrun_o == E_OVR[i], "R3 overrun", overrun_o, E_OVR[i]);
            check(fail_o == E_FL[i], "R5/R6 fail", fail_o, E_FL[i]);
            check(lat == E_LAT[i], "R7 latency", lat, E_LAT[i]);
            @(negedge clk);
            check(!done_o, "R8 done width", done_o, 0);
        end

        // R8: fail holds after a failing run until the next start
        run(55'd0, 55'd1, 55'd1 << 30, 1'b0, lat);
        repeat (5) @(negedge clk);
        check(fail_o == 1'b1, "R8 fail held", fail_o, 1);
        check(deadline_o == 55'd1048575, "R8 deadline held", deadline_o, 1048575);
        run(55'd100, 55'd10, 55'd50, 1'b0, lat);
        check(fail_o == 1'b0, "R8 fail cleared by start", fail_o, 0);

        // R9: start while busy is ignored
        @(negedge clk);
        deadline_i = 55'd100; period_i = 55'd10; counter_i = 55'd110; pending_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        deadline_i = 55'd0; period_i = 55'd1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; deadline_i = 55'd7; period_i = 55'd3;
        lat = 2;
        while (!done_o && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        check(deadline_o == 55'd130, "R9 deadline", deadline_o, 130);
        check(overrun_o == 32'd2, "R9 overrun", overrun_o, 2);
        check(lat == 7, "R9 latency", lat, 7);

        // R4: pending rescues equal-counter boundary
        run(55'd100, 55'd5, 55'd105, 1'b1, lat);
        check(deadline_o == 55'd105 && overrun_o == 0, "R4 pending at boundary", deadline_o, 105);

        // R1: reset in the middle of a run
        @(negedge clk);
        deadline_i = 55'd0; period_i = 55'd1; counter_i = 55'd1 << 30; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(deadline_o == '0 && overrun_o == '0 && !fail_o, "R1 mid-run reset", deadline_o, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL R7 global watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule